// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

This block is a byte-wide store of four registers organised as two banks, A (A1, A2) and B (B1, B2). A 2-bit operation code, sampled on every rising clock edge, decides what the edge does. The options are to push the input byte through all four registers as one four-deep pipeline, to load bank A or bank B as its own two-deep pipeline, or to freeze every register.

Any register can be read at any time through a combinational 2-bit select. The output is gated by an active-low enable. The enable is carried to the chip's pad ring as an active-high drive signal and does not drive an internal tri-state net.

A build-time parameter, `SHIFT_ON_LOAD`, chooses how a bank load treats the bank's second register. With 1, the old first-stage value moves down into the second register. With 0, only the first register is overwritten, and the second register can change only during a four-deep shift.

Top module: `mlp_pipe_reg`

## Requirements
- R1: While `rst` is high at a rising edge, all four registers become zero on that edge.
- R2: Operation code 2'b00 shifts on each edge: `din`→A1, A1→A2, A2→B1, B1→B2.
- R3: Operation code 2'b11 leaves all four registers unchanged.
- R4: Operation code 2'b10 writes `din` into A1 and leaves B1 and B2 unchanged. Operation code 2'b01 writes `din` into B1 and leaves A1 and A2 unchanged.
- R5: With `SHIFT_ON_LOAD`=1, a bank load (2'b10 or 2'b01) also moves the old value of the bank's first register into its second register.
- R6: With `SHIFT_ON_LOAD`=0, a bank load leaves the bank's second register unchanged.
- R7: `dout` shows B2 for `sel`=2'b00, B1 for 2'b01, A2 for 2'b10 and A1 for 2'b11. A change of `sel` appears on `dout` without a clock edge.
- R8: `dout_oe` is 0 while `oe_n` is 1 and is 1 while `oe_n` is 0. `oe_n` has no effect on register loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | W | Input byte |
| op | input | 2 | Operation code |
| sel | input | 2 | Read select |
| oe_n | input | 1 | Active-low output enable |
| dout | output | W | Selected register contents |
| dout_oe | output | 1 | Pad drive enable for `dout` |

## Verification
The assertions check on every edge that each operation code moves data correctly between the four registers. They also check the variant-dependent treatment of the second register in each bank, reset clearing, and the read-select mapping. Only the bench scenarios can show that long sequences with mixed operation codes leave the expected bytes in every stage, and that both variants behave correctly side by side from the same stimulus. The bench scenarios are also the only way to show that registers keep loading while the output is disabled, which the bench reads back after re-enabling the output.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  typedef enum logic [1:0] {
    OP_CHAIN  = 2'b00,
    OP_LOAD_B = 2'b01,
    OP_LOAD_A = 2'b10,
    OP_HOLD   = 2'b11
  } mlp_op_e;

  typedef enum logic [1:0] {
    RD_B2 = 2'b00,
    RD_B1 = 2'b01,
    RD_A2 = 2'b10,
    RD_A1 = 2'b11
  } mlp_rd_e;

  localparam int NUM_STAGES = 4;
endpackage

// File: rtl/mlp_ctrl.sv
module mlp_ctrl
  import mlp_pkg::*;
#(
  parameter bit SHIFT_ON_LOAD = 1'b1
) (
  input  logic [1:0] op,
  output logic       ld_a1,
  output logic       ld_a2,
  output logic       ld_b1,
  output logic       ld_b2,
  output logic       b_from_a
);
  mlp_op_e op_e;
  assign op_e = mlp_op_e'(op);

  always_comb begin
    ld_a1    = 1'b0;
    ld_a2    = 1'b0;
    ld_b1    = 1'b0;
    ld_b2    = 1'b0;
    b_from_a = 1'b0;
    case (op_e)
      OP_CHAIN: begin
        ld_a1    = 1'b1;
        ld_a2    = 1'b1;
        ld_b1    = 1'b1;
        ld_b2    = 1'b1;
        b_from_a = 1'b1;
      end
      OP_LOAD_A: begin
        ld_a1 = 1'b1;
        ld_a2 = SHIFT_ON_LOAD;
      end
      OP_LOAD_B: begin
        ld_b1 = 1'b1;
        ld_b2 = SHIFT_ON_LOAD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mlp_bank.sv
module mlp_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_first,
  input  logic         ld_second,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_first,
  output logic [W-1:0] q_second
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_first  <= '0;
      q_second <= '0;
    end else begin
      if (ld_first)  q_first  <= d_in;
      if (ld_second) q_second <= q_first;
    end
  end
endmodule

// File: rtl/mlp_readmux.sv
module mlp_readmux
  import mlp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] a2,
  input  logic [W-1:0] b1,
  input  logic [W-1:0] b2,
  output logic [W-1:0] y
);
  logic [W-1:0] taps [NUM_STAGES];

  assign taps[RD_B2] = b2;
  assign taps[RD_B1] = b1;
  assign taps[RD_A2] = a2;
  assign taps[RD_A1] = a1;

  assign y = taps[sel];
endmodule

// File: rtl/mlp_pipe_reg.sv
module mlp_pipe_reg #(
  parameter int W             = 8,
  parameter bit SHIFT_ON_LOAD = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [1:0]   op,
  input  logic [1:0]   sel,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         dout_oe
);
  logic         ld_a1, ld_a2, ld_b1, ld_b2, b_from_a;
  logic [W-1:0] a1_q, a2_q, b1_q, b2_q;
  logic [W-1:0] b_in;

  mlp_ctrl #(.SHIFT_ON_LOAD(SHIFT_ON_LOAD)) u_ctrl (
    .op       (op),
    .ld_a1    (ld_a1),
    .ld_a2    (ld_a2),
    .ld_b1    (ld_b1),
    .ld_b2    (ld_b2),
    .b_from_a (b_from_a)
  );

  mlp_bank #(.W(W)) u_bank_a (
    .clk       (clk),
    .rst       (rst),
    .ld_first  (ld_a1),
    .ld_second (ld_a2),
    .d_in      (din),
    .q_first   (a1_q),
    .q_second  (a2_q)
  );

  assign b_in = b_from_a ? a2_q : din;

  mlp_bank #(.W(W)) u_bank_b (
    .clk       (clk),
    .rst       (rst),
    .ld_first  (ld_b1),
    .ld_second (ld_b2),
    .d_in      (b_in),
    .q_first   (b1_q),
    .q_second  (b2_q)
  );

  mlp_readmux #(.W(W)) u_rdmux (
    .sel (sel),
    .a1  (a1_q),
    .a2  (a2_q),
    .b1  (b1_q),
    .b2  (b2_q),
    .y   (dout)
  );

  assign dout_oe = ~oe_n;
endmodule

// File: rtl/mlp_pipe_reg_chk.sv
module mlp_pipe_reg_chk #(
  parameter int W             = 8,
  parameter bit SHIFT_ON_LOAD = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] din,
  input logic [1:0]   op,
  input logic [1:0]   sel,
  input logic [W-1:0] dout,
  input logic [W-1:0] a1,
  input logic [W-1:0] a2,
  input logic [W-1:0] b1,
  input logic [W-1:0] b2
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (a1 == '0 && a2 == '0 && b1 == '0 && b2 == '0));

  p_chain_shift_r2: assert property (@(posedge clk) disable iff (rst)
    op == 2'b00 |=> (a1 == $past(din) && a2 == $past(a1) &&
                     b1 == $past(a2) && b2 == $past(b1)));

  p_hold_all_r3: assert property (@(posedge clk) disable iff (rst)
    op == 2'b11 |=> ($stable(a1) && $stable(a2) && $stable(b1) && $stable(b2)));

  // R4, R5 and R6 for bank A
  p_load_a_r4: assert property (@(posedge clk) disable iff (rst)
    op == 2'b10 |=> (a1 == $past(din) && $stable(b1) && $stable(b2) &&
                     a2 == (SHIFT_ON_LOAD ? $past(a1) : $past(a2))));

  // R4, R5 and R6 for bank B
  p_load_b_r4: assert property (@(posedge clk) disable iff (rst)
    op == 2'b01 |=> (b1 == $past(din) && $stable(a1) && $stable(a2) &&
                     b2 == (SHIFT_ON_LOAD ? $past(b1) : $past(b2))));

  p_select_map_r7: assert property (@(posedge clk) disable iff (rst)
    dout == ((sel == 2'b00) ? b2 : (sel == 2'b01) ? b1 : (sel == 2'b10) ? a2 : a1));
endmodule

bind mlp_pipe_reg mlp_pipe_reg_chk #(.W(W), .SHIFT_ON_LOAD(SHIFT_ON_LOAD)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .din  (din),
  .op   (op),
  .sel  (sel),
  .dout (dout),
  .a1   (a1_q),
  .a2   (a2_q),
  .b1   (b1_q),
  .b2   (b2_q)
);

// File: tb/test_mlp_pipe_reg.sv
module test_mlp_pipe_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [1:0]   op  = 2'b11;
  logic [1:0]   sel = 2'b00;
  logic         oe_n = 1'b0;
  logic [W-1:0] dout_s, dout_o;
  logic         oe_s, oe_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state: index 0=A1 1=A2 2=B1 3=B2; s=shifting variant, o=overwriting
  logic [W-1:0] ms [4];
  logic [W-1:0] mo [4];

  always #10 clk = ~clk;  // 50 MHz

  mlp_pipe_reg #(.W(W), .SHIFT_ON_LOAD(1'b1)) i_mlp_pipe_reg (
    .clk(clk), .rst(rst), .din(din), .op(op), .sel(sel), .oe_n(oe_n),
    .dout(dout_s), .dout_oe(oe_s));

  mlp_pipe_reg #(.W(W), .SHIFT_ON_LOAD(1'b0)) i_mlp_pipe_reg_ow (
    .clk(clk), .rst(rst), .din(din), .op(op), .sel(sel), .oe_n(oe_n),
    .dout(dout_o), .dout_oe(oe_o));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int idx_of_sel(input logic [1:0] s);
    // R7 mapping: 00->B2, 01->B1, 10->A2, 11->A1
    case (s)
      2'b00:   return 3;
      2'b01:   return 2;
      2'b10:   return 1;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(input logic [1:0] o, input logic [W-1:0] d);
    case (o)
      2'b00: begin
        ms[3] = ms[2]; ms[2] = ms[1]; ms[1] = ms[0]; ms[0] = d;
        mo[3] = mo[2]; mo[2] = mo[1]; mo[1] = mo[0]; mo[0] = d;
      end
      2'b10: begin
        ms[1] = ms[0]; ms[0] = d;
        mo[0] = d;
      end
      2'b01: begin
        ms[3] = ms[2]; ms[2] = d;
        mo[2] = d;
      end
      default: ;
    endcase
  endtask

  task automatic read_all(input string req);
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      #1;
      chk(req, dout_s, ms[idx_of_sel(2'(s))]);
      chk(req, dout_o, mo[idx_of_sel(2'(s))]);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [W-1:0] d, input string req);
    @(negedge clk);
    op = o; din = d;
    @(posedge clk);
    #1;
    model_step(o, d);
    read_all(req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; op = 2'b00; din = 8'hFF;
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) begin ms[i] = '0; mo[i] = '0; end
    read_all("R1 reset");
    @(negedge clk);
    rst = 1'b0; op = 2'b11;
  endtask

  task automatic t_chain();
    step(2'b00, 8'h11, "R2 chain");
    step(2'b00, 8'h22, "R2 chain");
    step(2'b00, 8'h33, "R2 chain");
    step(2'b00, 8'h44, "R2 chain");
    step(2'b00, 8'h55, "R2 chain");
  endtask

  task automatic t_hold();
    step(2'b11, 8'hEE, "R3 hold");
    step(2'b11, 8'h0F, "R3 hold");
  endtask

  task automatic t_load_a();
    step(2'b10, 8'hA5, "R4 R5 R6 load A");
    step(2'b10, 8'h5A, "R4 R5 R6 load A");
  endtask

  task automatic t_load_b();
    step(2'b01, 8'hC3, "R4 R5 R6 load B");
    step(2'b01, 8'h3C, "R4 R5 R6 load B");
  endtask

  task automatic t_mixed();
    step(2'b10, 8'h01, "R2 R6 mixed");
    step(2'b00, 8'h02, "R2 R6 mixed");
    step(2'b01, 8'h03, "R2 R6 mixed");
    step(2'b11, 8'h04, "R3 mixed");
    step(2'b00, 8'h05, "R2 mixed");
  endtask

  task automatic t_select_comb();
    // change sel away from any edge; dout must follow at once
    @(negedge clk);
    op = 2'b11;
    for (int s = 3; s >= 0; s--) begin
      sel = 2'(s);
      #1;
      chk("R7 select", dout_s, ms[idx_of_sel(2'(s))]);
    end
  endtask

  task automatic t_oe();
    @(negedge clk);
    oe_n = 1'b1;
    #1;
    chk("R8 oe off", {7'd0, oe_s}, 8'd0);
    chk("R8 oe off", {7'd0, oe_o}, 8'd0);
    step(2'b00, 8'h9C, "R8 load while off");
    step(2'b10, 8'h6D, "R8 load while off");
    @(negedge clk);
    oe_n = 1'b0;
    #1;
    chk("R8 oe on", {7'd0, oe_s}, 8'd1);
    read_all("R8 state after oe");
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_chain();
    t_hold();
    t_load_a();
    t_load_b();
    t_mixed();
    t_select_comb();
    t_oe();
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule